// File: doc/BRIEF.md
# Masked Interrupt Aggregator with Queued Done

This block gathers interrupt conditions from a set of processing channels, a set of execution units and the controller itself into one status register. It drives a single level-sensitive request line to the host. Each condition must pass an enable bit in a host-written mask register before it can set its status bit. Execution-unit conditions must also pass a per-unit enable input. The host reads the status register to find the source, then acknowledges bits by writing ones to a clear register.

Level conditions that are still active when acknowledged drop their status bit for one cycle and then set it again. The request line stays high through that cycle.

Channel Done conditions are handled differently. Each channel keeps a saturating pending counter, so Done events that arrive before the host acknowledges are not lost. Each acknowledge with events still pending replays one event after a one-cycle gap, and the count goes down by one.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, the mask register, the status register, every pending counter and every overflow flag are zero, and `irq_out` is low.
- R2: The mask register is read and written at address 0. A condition whose mask bit is 0 never sets its status bit, and a masked Done event is not counted as pending.
- R3: Status, mask and clear share one bit layout. Channel c has its Done bit at position 2c and its Error bit at 2c+1. Execution unit e sits at 2*NUM_CH+e. The controller-error bit is at 2*NUM_CH+NUM_EU. Status is read at address 1.
- R4: `irq_out` is high whenever any status bit is set or a replay gap is in progress. It is low once every status bit is clear and no replay is scheduled.
- R5: Writing to address 2 clears every status bit whose data bit is 1. Data bits that are 0 leave the status unchanged. Address 2 reads back as zero.
- R6: When a level condition is still active in the cycle its bit is cleared, the bit reads 0 for exactly one cycle and then reads 1 again, with `irq_out` high throughout.
- R7: A Done event arriving while that channel's Done bit is set, or during its replay gap, adds one to the channel's pending count.
- R8: Clearing a set Done bit with a pending count of zero leaves it clear. With a nonzero count, the bit reads 0 for one cycle and then 1, and the count drops by one.
- R9: The pending count saturates at 15. A Done event that arrives at saturation sets that channel's overflow flag, which is bit c at address 3. Writing 1 to that bit clears the flag.
- R10: A new event and a clear of the same bit in the same cycle leave the bit set. For a level bit the event is a 0-to-1 change of its gated condition; for a Done bit it is any cycle with the event high.
- R11: An execution-unit condition sets its bit only while its `eu_enable` input is 1. Channel and controller conditions do not depend on `eu_enable`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_done_evt | input | NUM_CH | Per-channel Done event; each cycle high counts as one event |
| ch_err_evt | input | NUM_CH | Per-channel Error condition |
| eu_evt | input | NUM_EU | Per-unit condition |
| eu_enable | input | NUM_EU | Per-unit enable applied before the mask |
| ctl_err_evt | input | 1 | Controller error condition |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 mask, 1 status, 2 clear, 3 overflow |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for the selected register, combinational |
| irq_out | output | 1 | Level interrupt request to the host |

## Verification
The bench replays Done bursts of every length from 0 to 17 and counts how many times the bit reappears across successive clears. A counter that drops events, fails to saturate or never raises its overflow flag shows up as a wrong replay count or a wrong flag. The bench walks a single mask bit across the whole layout and fires every source at once. A swapped field or a leaking mask therefore shows up as the wrong bit set.

It also times the one-cycle gap after clearing a held condition, because a design that lowers `irq_out` in that cycle, or never sets the bit again, fails there. Finally, it collides a clear with a fresh event in the same cycle; a design that lets the clear win loses that event.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
   typedef enum logic [1:0] {
      REG_MASK = 2'd0,
      REG_STAT = 2'd1,
      REG_ACK  = 2'd2,
      REG_OVF  = 2'd3
   } reg_sel_e;

   function automatic int stat_width(input int nch, input int neu);
      return 2 * nch + neu + 1;
   endfunction
endpackage

// File: rtl/irq_level_latch.sv
module irq_level_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic cond,
   input  logic ack,
   output logic st,
   output logic gap
);
   logic cond_q;
   logic rise;
   logic st_n;
   logic gap_n;

   always_comb begin
      rise  = cond & ~cond_q;
      st_n  = (st & ~ack) | (cond & (~ack | rise));
      gap_n = ack & st & cond & ~rise;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cond_q <= 1'b0;
         st     <= 1'b0;
         gap    <= 1'b0;
      end else begin
         cond_q <= cond;
         st     <= st_n;
         gap    <= gap_n;
      end
   end

   assert_mask_block_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!st && !cond) |=> !st);
   assert_held_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && st && cond && !rise) |=> (!st && gap));
   assert_event_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && rise) |=> st);
endmodule

// File: rtl/irq_done_queue.sv
module irq_done_queue #(
   parameter int CNT_W = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic ack,
   input  logic ovf_ack,
   output logic st,
   output logic gap,
   output logic ovf
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_n;
   logic             st_n;
   logic             gap_n;
   logic             ovf_set;
   logic             busy;

   always_comb begin
      busy    = st | gap;
      st_n    = st;
      gap_n   = 1'b0;
      cnt_n   = cnt;
      ovf_set = 1'b0;
      if (ack && st) begin
         if (evt) begin
            st_n = 1'b1;
         end else if (cnt != '0) begin
            st_n  = 1'b0;
            gap_n = 1'b1;
            cnt_n = cnt - 1'b1;
         end else begin
            st_n = 1'b0;
         end
      end else begin
         if (gap) st_n = 1'b1;
         if (evt) begin
            if (busy) begin
               if (cnt == CNT_MAX) ovf_set = 1'b1;
               else                cnt_n   = cnt + 1'b1;
            end else begin
               st_n = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         st  <= 1'b0;
         gap <= 1'b0;
         ovf <= 1'b0;
      end else begin
         cnt <= cnt_n;
         st  <= st_n;
         gap <= gap_n;
         ovf <= (ovf & ~ovf_ack) | ovf_set;
      end
   end

   assert_cnt_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CNT_MAX && evt && busy && !(ack && st)) |=> (cnt == CNT_MAX && ovf));
   assert_pend_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && st && !evt && cnt != '0) |=> (!st && cnt == CNT_W'($past(cnt) - 1'b1)));
   assert_gap_reassert_R8: assert property (@(posedge clk) disable iff (!rst_n)
      gap |=> st);
   assert_empty_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && st && !evt && cnt == '0) |=> (!st && !gap));
   assert_pend_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && busy && !(ack && st) && cnt != CNT_MAX) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
   import irq_agg_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int NUM_EU = 4,
   parameter int CNT_W  = 4,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] ch_done_evt,
   input  logic [NUM_CH-1:0] ch_err_evt,
   input  logic [NUM_EU-1:0] eu_evt,
   input  logic [NUM_EU-1:0] eu_enable,
   input  logic              ctl_err_evt,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_out
);
   localparam int STAT_W  = stat_width(NUM_CH, NUM_EU);
   localparam int EU_BASE = 2 * NUM_CH;
   localparam int CTL_BIT = STAT_W - 1;

   if (NUM_CH < 1 || NUM_EU < 1) begin : g_bad_count
      $error("irq_aggregator: NUM_CH and NUM_EU must be at least 1");
   end
   if (STAT_W >= DATA_W) begin : g_bad_width
      $error("irq_aggregator: status layout does not fit below DATA_W");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("irq_aggregator: CNT_W must be at least 1");
   end

   reg_sel_e          sel;
   logic [STAT_W-1:0] mask_q;
   logic [STAT_W-1:0] ack;
   logic [NUM_CH-1:0] ovf_ack;
   logic [STAT_W-1:0] status;
   logic [STAT_W-1:0] gap;
   logic [NUM_CH-1:0] ovf;
   logic              unused_wdata;

   assign sel          = reg_sel_e'(reg_addr);
   assign ack          = (reg_wr && sel == REG_ACK) ? reg_wdata[STAT_W-1:0] : '0;
   assign ovf_ack      = (reg_wr && sel == REG_OVF) ? reg_wdata[NUM_CH-1:0] : '0;
   assign unused_wdata = ^reg_wdata[DATA_W-1:STAT_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        mask_q <= '0;
      else if (reg_wr && sel == REG_MASK) mask_q <= reg_wdata[STAT_W-1:0];
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      irq_done_queue #(.CNT_W(CNT_W)) u_done (
         .clk     (clk),
         .rst_n   (rst_n),
         .evt     (ch_done_evt[c] & mask_q[2*c]),
         .ack     (ack[2*c]),
         .ovf_ack (ovf_ack[c]),
         .st      (status[2*c]),
         .gap     (gap[2*c]),
         .ovf     (ovf[c])
      );
      irq_level_latch u_err (
         .clk   (clk),
         .rst_n (rst_n),
         .cond  (ch_err_evt[c] & mask_q[2*c+1]),
         .ack   (ack[2*c+1]),
         .st    (status[2*c+1]),
         .gap   (gap[2*c+1])
      );
   end

   for (genvar e = 0; e < NUM_EU; e++) begin : g_eu
      irq_level_latch u_eu (
         .clk   (clk),
         .rst_n (rst_n),
         .cond  (eu_evt[e] & eu_enable[e] & mask_q[EU_BASE+e]),
         .ack   (ack[EU_BASE+e]),
         .st    (status[EU_BASE+e]),
         .gap   (gap[EU_BASE+e])
      );
   end

   irq_level_latch u_ctl (
      .clk   (clk),
      .rst_n (rst_n),
      .cond  (ctl_err_evt & mask_q[CTL_BIT]),
      .ack   (ack[CTL_BIT]),
      .st    (status[CTL_BIT]),
      .gap   (gap[CTL_BIT])
   );

   assign irq_out = (|status) | (|gap);

   always_comb begin
      unique case (sel)
         REG_MASK: reg_rdata = DATA_W'(mask_q);
         REG_STAT: reg_rdata = DATA_W'(status);
         REG_OVF:  reg_rdata = DATA_W'(ovf);
         default:  reg_rdata = '0;
      endcase
   end

   for (genvar i = 0; i < STAT_W; i++) begin : g_chk
      assert_drop_needs_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(status[i]) |-> $past(ack[i]));
   end
   assert_mask_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && sel == REG_MASK) |=> (mask_q == $past(reg_wdata[STAT_W-1:0])));
   assert_irq_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_out) |-> (status == '0));
endmodule

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
   localparam int NCH = 4;
   localparam int NEU = 4;
   localparam int SW  = 2 * NCH + NEU + 1;
   localparam logic [31:0] ALL = (32'd1 << SW) - 1;

   logic            clk = 1'b0;
   logic            rst_n;
   logic [NCH-1:0]  ch_done_evt;
   logic [NCH-1:0]  ch_err_evt;
   logic [NEU-1:0]  eu_evt;
   logic [NEU-1:0]  eu_enable;
   logic            ctl_err_evt;
   logic            reg_wr;
   logic [1:0]      reg_addr;
   logic [31:0]     reg_wdata;
   logic [31:0]     reg_rdata;
   logic            irq_out;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   irq_aggregator #(.NUM_CH(NCH), .NUM_EU(NEU), .CNT_W(4), .DATA_W(32)) u_dut (
      .clk(clk), .rst_n(rst_n), .ch_done_evt(ch_done_evt), .ch_err_evt(ch_err_evt),
      .eu_evt(eu_evt), .eu_enable(eu_enable), .ctl_err_evt(ctl_err_evt),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_out(irq_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] v);
      reg_addr = a;
      #1;
      v = reg_rdata;
   endtask

   task automatic fire_all;
      ch_done_evt = '1; ch_err_evt = '1; eu_evt = '1; eu_enable = '1; ctl_err_evt = 1'b1;
      @(negedge clk);
      ch_done_evt = '0; ch_err_evt = '0; eu_evt = '0; ctl_err_evt = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      rst_n = 1'b0; ch_done_evt = '0; ch_err_evt = '0; eu_evt = '0; eu_enable = '0;
      ctl_err_evt = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(2'd0, v); chk("R1 mask", v, 0);
      rd(2'd1, v); chk("R1 status", v, 0);
      rd(2'd3, v); chk("R1 overflow", v, 0);
      chk("R1 irq", {31'd0, irq_out}, 0);

      // R2 mask register read back
      wr(2'd0, ALL);
      rd(2'd0, v); chk("R2 mask readback", v, ALL);

      // R2 R3 walking mask bit over the whole layout
      for (int b = 0; b < SW; b++) begin
         wr(2'd0, 32'd1 << b);
         fire_all();
         rd(2'd1, v); chk("R3 walking bit status", v, 32'd1 << b);
         chk("R4 irq with bit set", {31'd0, irq_out}, 1);
         wr(2'd2, ALL);
         rd(2'd1, v); chk("R5 clear all", v, 0);
         chk("R4 irq low when clear", {31'd0, irq_out}, 0);
      end

      // R2 masked Done events are neither latched nor counted
      wr(2'd0, ALL & ~32'd1);
      ch_done_evt[0] = 1'b1; repeat (3) @(negedge clk); ch_done_evt[0] = 1'b0;
      wr(2'd0, ALL);
      @(negedge clk);
      rd(2'd1, v); chk("R2 masked done ignored", v, 0);

      // R11 unit enable gates only execution-unit conditions
      eu_enable = '0; eu_evt = '1; ch_err_evt = '1;
      @(negedge clk);
      eu_evt = '0; ch_err_evt = '0;
      rd(2'd1, v); chk("R11 enable gates units only", v, 32'h0AA);
      wr(2'd2, ALL);
      eu_enable = '1;

      // R5 zero bits in clear write have no effect
      ch_err_evt[1] = 1'b1; @(negedge clk); ch_err_evt[1] = 1'b0;
      wr(2'd2, 32'd0);
      rd(2'd1, v); chk("R5 zero clear no effect", v, 32'h8);
      rd(2'd2, v); chk("R5 clear reads zero", v, 0);
      wr(2'd2, 32'h8);
      rd(2'd1, v); chk("R5 clear one bit", v, 0);

      // R6 held level condition: one-cycle gap, irq stays high
      ctl_err_evt = 1'b1; @(negedge clk);
      rd(2'd1, v); chk("R6 held sets", v, 32'd1 << (SW - 1));
      wr(2'd2, 32'd1 << (SW - 1));
      rd(2'd1, v); chk("R6 gap reads zero", v, 0);
      chk("R6 irq high in gap", {31'd0, irq_out}, 1);
      @(negedge clk);
      rd(2'd1, v); chk("R6 bit returns", v, 32'd1 << (SW - 1));
      ctl_err_evt = 1'b0;
      wr(2'd2, 32'd1 << (SW - 1));
      @(negedge clk);
      rd(2'd1, v); chk("R6 released stays clear", v, 0);
      chk("R4 irq low after release", {31'd0, irq_out}, 0);

      // R10 level event collides with clear
      ch_err_evt[0] = 1'b1; @(negedge clk); ch_err_evt[0] = 1'b0;
      @(negedge clk);
      ch_err_evt[0] = 1'b1;
      wr(2'd2, 32'h2);
      ch_err_evt[0] = 1'b0;
      rd(2'd1, v); chk("R10 level event wins", v, 32'h2);
      wr(2'd2, 32'h2); @(negedge clk);
      rd(2'd1, v); chk("R10 later clear works", v, 0);

      // R10 Done event collides with clear
      ch_done_evt[2] = 1'b1; @(negedge clk); ch_done_evt[2] = 1'b0;
      ch_done_evt[2] = 1'b1;
      wr(2'd2, 32'h10);
      ch_done_evt[2] = 1'b0;
      rd(2'd1, v); chk("R10 done event wins", v, 32'h10);
      wr(2'd2, 32'h10); @(negedge clk);
      rd(2'd1, v); chk("R8 empty queue stays clear", v, 0);

      // R7 R8 R9 Done burst sweep
      for (int n = 0; n <= 17; n++) begin
         int c;
         int seen;
         int expv;
         c = n % NCH;
         seen = 0;
         expv = (n > 16) ? 16 : n;
         if (n > 0) begin
            ch_done_evt[c] = 1'b1;
            repeat (n) @(negedge clk);
            ch_done_evt[c] = 1'b0;
         end
         for (int k = 0; k < 20; k++) begin
            rd(2'd1, v);
            if (v[2*c] !== 1'b1) break;
            seen++;
            wr(2'd2, 32'd1 << (2 * c));
            if (n == 3 && seen == 1) begin
               rd(2'd1, v); chk("R8 pending gap reads zero", v, 0);
               chk("R8 irq high in gap", {31'd0, irq_out}, 1);
            end
            @(negedge clk);
         end
         chk("R7 R9 replay count", seen, expv);
         rd(2'd3, v); chk("R9 overflow flag", v, (n > 16) ? (32'd1 << c) : 32'd0);
         wr(2'd3, 32'd1 << c);
         rd(2'd3, v); chk("R9 overflow cleared", v, 0);
      end

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule